// File: doc/BRIEF.md
# SAR ADC Phase Sequencer

This block paces one successive-approximation conversion of a 10-bit ADC core from the CPU clock. A programmable divider makes a one-cycle enable pulse that marks the end of each ADC clock period, so the block uses one clock domain. A start request opens a fixed lead-in of CPU cycles. An acquisition window follows, during which the sample/hold output is high. Then comes one conversion period per result bit. The block drives a trial word to the core's DAC and reads back a comparator decision. After a short transfer delay the finished word goes into the result register and a completion flag is set. The interrupt follows the flag a fixed number of CPU cycles later.

The ADC period is `div_sel + 1` CPU cycles. The acquisition window is `2 + acq_sel` ADC periods. Both settings are captured when a start is accepted, so one conversion always runs with one timing. The flag and the interrupt stay set until a write-one clear pulse arrives.

Top module: `sar_phase_seq`

## Requirements
- R1: While reset is held, busy, sample_hold, converting, flag, irq and result are all zero.
- R2: A start pulse taken by a clock edge while idle raises busy after that edge and raises sample_hold two CPU cycles after that edge.
- R3: sample_hold stays high for exactly (2 + acq_sel) × (div_sel + 1) CPU cycles.
- R4: converting rises in the same cycle that sample_hold falls and lasts 10 × (div_sel + 1) CPU cycles. In its first cycle the trial word is 0x200 (MSB only). Bits are resolved from MSB to LSB, one per ADC period.
- R5: The comparator input is sampled in the last CPU cycle of each conversion period. 1 keeps the trial bit and 0 clears it, and the next lower bit is set as the new trial. A comparator that reports input ≥ trial therefore yields result equal to the input code.
- R6: The result register is loaded, flag is set and busy falls together, two CPU cycles after converting falls.
- R7: irq rises two CPU cycles after flag rises and stays high as long as flag stays high.
- R8: A flag_clr pulse clears flag and irq at the next clock edge.
- R9: A start pulse while busy is ignored. The running conversion's timing and result are unchanged, and no second conversion follows.
- R10: Changes to div_sel and acq_sel while busy have no effect on the running conversion.
- R11: result holds its value between completions, including across a flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soc | input | 1 | Start-of-conversion request, one cycle |
| div_sel | input | DIV_W | ADC period minus one, in CPU cycles |
| acq_sel | input | ACQ_W | Extra acquisition periods beyond two |
| cmp_in | input | 1 | Comparator decision: 1 = input ≥ trial |
| flag_clr | input | 1 | Write-one clear of flag and irq |
| busy | output | 1 | A conversion is in progress |
| sample_hold | output | 1 | Acquisition window active |
| converting | output | 1 | Bit-resolution phase active |
| trial | output | RES_W | Trial word to the DAC |
| result | output | RES_W | Last completed conversion |
| flag | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default widths, a 4-bit divider setting and a 3-bit acquisition setting. This makes every acquisition length and the short and longest ADC periods cheap enough to sweep in full. Every 10-bit input code is converted once at the fastest setting, which covers each bit decision pattern of the binary search. Selected runs inject a second start and move both settings in mid-conversion, to show the latched timing holds.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LEAD,
      PH_ACQ,
      PH_CONV,
      PH_XFER
   } phase_t;
endpackage

// File: rtl/sarseq_clkdiv.sv
module sarseq_clkdiv #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = !clr && (cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sarseq_sar.sv
module sarseq_sar #(
   parameter int RES_W = 10,
   localparam int IW = $clog2(RES_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             step,
   input  logic [IW-1:0]    idx,
   input  logic             cmp,
   output logic [RES_W-1:0] word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word <= '0;
      end else if (init) begin
         word <= {1'b1, {(RES_W-1){1'b0}}};
      end else if (step) begin
         for (int b = 0; b < RES_W; b++) begin
            if (b == int'(idx))          word[b] <= cmp;
            else if (b == int'(idx) - 1) word[b] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sarseq_ctrl.sv
module sarseq_ctrl
   import sarseq_pkg::*;
#(
   parameter int RES_W   = 10,
   parameter int ACQ_W   = 3,
   parameter int SOC_DLY = 2,
   parameter int EOC_DLY = 2,
   localparam int IW = $clog2(RES_W),
   localparam int CW = ACQ_W + $clog2(RES_W + SOC_DLY + EOC_DLY) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soc,
   input  logic             tick,
   input  logic [ACQ_W-1:0] acq_l,
   output phase_t           ph,
   output logic             accept,
   output logic             sar_init,
   output logic             sar_step,
   output logic [IW-1:0]    idx,
   output logic             done,
   output logic             div_clr
);
   localparam logic [CW-1:0] LEAD_LAST = CW'(SOC_DLY - 1);
   localparam logic [CW-1:0] CONV_LAST = CW'(RES_W - 1);
   localparam logic [CW-1:0] XFER_LAST = CW'(EOC_DLY - 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] acq_last;

   assign acq_last = CW'(acq_l) + CW'(1);
   assign accept   = (ph == PH_IDLE) && soc;
   assign sar_init = (ph == PH_ACQ) && tick && (cnt == acq_last);
   assign sar_step = (ph == PH_CONV) && tick;
   assign idx      = IW'(RES_W - 1) - cnt[IW-1:0];
   assign done     = (ph == PH_XFER) && (cnt == XFER_LAST);
   assign div_clr  = !((ph == PH_ACQ) || (ph == PH_CONV));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else begin
         unique case (ph)
            PH_IDLE: if (soc) begin
               ph  <= PH_LEAD;
               cnt <= '0;
            end
            PH_LEAD: if (cnt == LEAD_LAST) begin
               ph  <= PH_ACQ;
               cnt <= '0;
            end else cnt <= cnt + 1'b1;
            PH_ACQ: if (tick) begin
               if (cnt == acq_last) begin
                  ph  <= PH_CONV;
                  cnt <= '0;
               end else cnt <= cnt + 1'b1;
            end
            PH_CONV: if (tick) begin
               if (cnt == CONV_LAST) begin
                  ph  <= PH_XFER;
                  cnt <= '0;
               end else cnt <= cnt + 1'b1;
            end
            PH_XFER: if (cnt == XFER_LAST) begin
               ph  <= PH_IDLE;
               cnt <= '0;
            end else cnt <= cnt + 1'b1;
            default: begin
               ph  <= PH_IDLE;
               cnt <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/sarseq_notify.sv
module sarseq_notify #(
   parameter int IRQ_DLY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag,
   output logic irq
);
   logic [IRQ_DLY:0] stage;

   assign stage[0] = flag;
   assign irq      = stage[IRQ_DLY];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   for (genvar k = 1; k <= IRQ_DLY; k++) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage[k] <= 1'b0;
         else        stage[k] <= stage[k-1] && !clr;
      end
   end
endmodule

// File: rtl/sar_phase_seq.sv
module sar_phase_seq
   import sarseq_pkg::*;
#(
   parameter int RES_W   = 10,
   parameter int DIV_W   = 4,
   parameter int ACQ_W   = 3,
   parameter int SOC_DLY = 2,
   parameter int EOC_DLY = 2,
   parameter int IRQ_DLY = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soc,
   input  logic [DIV_W-1:0] div_sel,
   input  logic [ACQ_W-1:0] acq_sel,
   input  logic             cmp_in,
   input  logic             flag_clr,
   output logic             busy,
   output logic             sample_hold,
   output logic             converting,
   output logic [RES_W-1:0] trial,
   output logic [RES_W-1:0] result,
   output logic             flag,
   output logic             irq
);
   localparam int IW = $clog2(RES_W);

   if (RES_W < 2)   begin : g_bad_res  $error("RES_W must be at least 2");   end
   if (DIV_W < 1)   begin : g_bad_div  $error("DIV_W must be at least 1");   end
   if (ACQ_W < 1)   begin : g_bad_acq  $error("ACQ_W must be at least 1");   end
   if (SOC_DLY < 1) begin : g_bad_soc  $error("SOC_DLY must be at least 1"); end
   if (EOC_DLY < 1) begin : g_bad_eoc  $error("EOC_DLY must be at least 1"); end
   if (IRQ_DLY < 1) begin : g_bad_irq  $error("IRQ_DLY must be at least 1"); end

   phase_t           ph;
   logic             accept, sar_init, sar_step, done, div_clr, tick;
   logic [IW-1:0]    idx;
   logic [DIV_W-1:0] div_l;
   logic [ACQ_W-1:0] acq_l;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_l <= '0;
         acq_l <= '0;
      end else if (accept) begin
         div_l <= div_sel;
         acq_l <= acq_sel;
      end
   end

   sarseq_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .clr(div_clr), .div(div_l), .tick(tick)
   );

   sarseq_ctrl #(
      .RES_W(RES_W), .ACQ_W(ACQ_W), .SOC_DLY(SOC_DLY), .EOC_DLY(EOC_DLY)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .soc(soc), .tick(tick), .acq_l(acq_l),
      .ph(ph), .accept(accept), .sar_init(sar_init), .sar_step(sar_step),
      .idx(idx), .done(done), .div_clr(div_clr)
   );

   sarseq_sar #(.RES_W(RES_W)) u_sar (
      .clk(clk), .rst_n(rst_n), .init(sar_init), .step(sar_step),
      .idx(idx), .cmp(cmp_in), .word(trial)
   );

   sarseq_notify #(.IRQ_DLY(IRQ_DLY)) u_note (
      .clk(clk), .rst_n(rst_n), .set(done), .clr(flag_clr),
      .flag(flag), .irq(irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    result <= '0;
      else if (done) result <= trial;
   end

   assign busy        = (ph != PH_IDLE);
   assign sample_hold = (ph == PH_ACQ);
   assign converting  = (ph == PH_CONV);
endmodule

// File: rtl/sarseq_chk.sv
module sarseq_chk #(
   parameter int RES_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flag_clr,
   input logic             busy,
   input logic             sample_hold,
   input logic             converting,
   input logic [RES_W-1:0] result,
   input logic             flag,
   input logic             irq
);
   assert_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sample_hold) |-> $past(busy) && $past(busy, 2));

   assert_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sample_hold |-> busy && !converting);

   assert_handoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sample_hold) |-> converting);

   assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> flag && $fell(busy));

   assert_irq_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(flag) && $past(flag, 2));

   assert_irq_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);

   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr |=> !irq);
endmodule

bind sar_phase_seq sarseq_chk #(.RES_W(RES_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr), .busy(busy),
   .sample_hold(sample_hold), .converting(converting), .result(result),
   .flag(flag), .irq(irq)
);

// File: tb/sim_sar_phase_seq.sv
module sim_sar_phase_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soc = 1'b0;
   logic [3:0] div_sel = '0;
   logic [2:0] acq_sel = '0;
   logic       flag_clr = 1'b0;
   logic [9:0] vin = '0;
   logic       cmp_in;
   logic       busy, sample_hold, converting, flag, irq;
   logic [9:0] trial, result;
   int         n_chk = 0;
   int         n_err = 0;
   int         cyc = 0;

   always #10 clk = ~clk;

   assign cmp_in = (vin >= trial);

   sar_phase_seq u0 (
      .clk(clk), .rst_n(rst_n), .soc(soc), .div_sel(div_sel), .acq_sel(acq_sel),
      .cmp_in(cmp_in), .flag_clr(flag_clr), .busy(busy), .sample_hold(sample_hold),
      .converting(converting), .trial(trial), .result(result), .flag(flag), .irq(irq)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000) begin
         n_err++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
         $finish;
      end
   end

   task automatic run_conv(input int d, input int a, input int v, input bit disturb);
      int p = d + 1;
      int shl = 2 + a;
      int t_rise = -1, t_fall = -1, t_conv = -1, t_cend = -1, t_flag = -1, t_irq = -1;
      int res_at = -1, trial0 = -1;
      bit busy_at = 1'b1;
      div_sel = 4'(d);
      acq_sel = 3'(a);
      vin     = 10'(v);
      soc     = 1'b1;
      @(negedge clk);
      soc = 1'b0;
      chk(busy == 1'b1 && sample_hold == 1'b0, "R2 busy at accept", busy, 1);
      for (int i = 0; i < 700; i++) begin
         if (disturb && i == 4) begin
            soc = 1'b1;
            div_sel = 4'(d + 7);
            acq_sel = 3'(a + 3);
         end
         if (disturb && i == 5) soc = 1'b0;
         if (sample_hold && t_rise < 0) t_rise = i;
         if (!sample_hold && t_rise >= 0 && t_fall < 0) t_fall = i;
         if (converting && t_conv < 0) begin t_conv = i; trial0 = int'(trial); end
         if (!converting && t_conv >= 0 && t_cend < 0) t_cend = i;
         if (flag && t_flag < 0) begin t_flag = i; res_at = int'(result); busy_at = busy; end
         if (irq && t_irq < 0) begin t_irq = i; break; end
         @(negedge clk);
      end
      chk(t_rise == 2, disturb ? "R10 lead" : "R2 lead", t_rise, 2);
      chk(t_fall - t_rise == shl * p, disturb ? "R10 acq width" : "R3 acq width",
          t_fall - t_rise, shl * p);
      chk(t_conv == t_fall, "R4 conv start", t_conv, t_fall);
      chk(trial0 == 512, "R4 first trial", trial0, 512);
      chk(t_cend - t_conv == 10 * p, disturb ? "R10 conv width" : "R4 conv width",
          t_cend - t_conv, 10 * p);
      chk(t_flag - t_cend == 2, "R6 transfer delay", t_flag - t_cend, 2);
      chk(busy_at == 1'b0, "R6 busy low at flag", busy_at, 0);
      chk(res_at == v, disturb ? "R9 result" : "R5 result", res_at, v);
      chk(t_irq - t_flag == 2, "R7 irq delay", t_irq - t_flag, 2);
      repeat (3) @(negedge clk);
      chk(irq && flag, "R7 irq held", irq, 1);
      if (disturb) chk(busy == 1'b0, "R9 no second conversion", busy, 0);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      chk(!flag && !irq, "R8 clear", {flag, irq}, 0);
      @(negedge clk);
      chk(int'(result) == v, "R11 result held", result, v);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !sample_hold && !converting, "R1 phase outputs", {busy, sample_hold, converting}, 0);
      chk(!flag && !irq && result == '0, "R1 flag irq result", {flag, irq}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 R3 R4 R6 R7: timing sweep over settings
      for (int d = 0; d < 5; d++) begin
         for (int a = 0; a < 8; a++) begin
            run_conv((d == 4) ? 15 : d, a, (d * 173 + a * 101 + 5) % 1024, 1'b0);
         end
      end
      // R9 R10: disturbances during busy
      run_conv(0, 0, 1023, 1'b1);
      run_conv(2, 1, 0, 1'b1);
      run_conv(15, 7, 341, 1'b1);
      run_conv(5, 4, 682, 1'b1);
      // R5: every input code at the fastest setting
      for (int v = 0; v < 1024; v++) run_conv(0, 0, v, 1'b0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule